// File: doc/BRIEF.md
# Instruction Stream Buffer Prefetcher

This block fronts a small direct-mapped instruction cache and adds a one-entry stream buffer between that cache and the next memory level. A fetch that misses in both the cache and the buffer sends two block reads to memory. The first is the demand read for the requested block. The second is a prefetch of the next sequential block. The demand block goes into the cache and is returned to the CPU. The prefetched block is parked in the stream buffer only.

A later fetch that misses in the cache but matches the buffer is served from the buffer without a memory read. That block is copied into the cache, and the prefetch of the block after it starts straight away. Sequential instruction streams therefore run with one memory read per block, and the read is hidden behind execution.

The CPU side accepts one fetch at a time, and addresses are block addresses. The memory side is a valid/ready request channel with a demand/prefetch tag bit and an in-order response channel of variable latency. The response carries the same tag bit and one full block. Each CPU response comes with a one-cycle status pulse that classifies it as a cache hit, a buffer hit or a full miss. Three counters accumulate those pulses.

Top module: `isb_prefetch_top`

## Requirements
- R1: After reset the block is ready for a fetch, has no CPU response and no memory request pending, and all three counters read zero.
- R2: A fetch whose block is resident in the cache returns that block's data with no memory request. The cache index is the low log2(SETS) bits of the block address, so a block at the same index with a different address evicts it.
- R3: A fetch that misses in both the cache and the buffer issues exactly two memory requests in this order: block i with the tag bit 0 (demand), then block i+1 with the tag bit 1 (prefetch). Addresses wrap modulo 2^ADDR_W.
- R4: On a full miss the CPU response carries the demand block's data and is returned as soon as the demand response (tag bit 0) arrives, even if the prefetch request or response is still outstanding.
- R5: The prefetched block i+1 is not written into the cache, so a following fetch of i+1 is classified as a buffer hit and not a cache hit.
- R6: A fetch that misses in the cache but hits a filled buffer entry returns the buffered data with no memory read for it, writes the block into the cache so that a repeat fetch is a cache hit, and issues a prefetch (tag bit 1) for the next block.
- R7: A fetch that matches the buffer entry while that entry's prefetch is still outstanding waits for the data and issues no additional memory request.
- R8: A full miss invalidates the buffer entry. The data of a prefetch issued before the invalidation is discarded when it arrives and never reaches the CPU or the cache.
- R9: Every CPU response comes with exactly one of the status pulses hit, buffer hit or miss, and never otherwise. The counter of that class rises by one in the following cycle.
- R10: A memory request that is not accepted holds its valid, address and tag bit unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Fetch request valid |
| cpu_req_addr | input | ADDR_W | Block address to fetch |
| cpu_req_ready | output | 1 | Block can accept a fetch |
| cpu_rsp_valid | output | 1 | Fetch data valid (one cycle) |
| cpu_rsp_data | output | DATA_W | Fetched block |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Block address to read |
| mem_req_pf | output | 1 | 1 for a prefetch, 0 for a demand read |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_pf | input | 1 | Tag bit of the returned block |
| mem_rsp_data | input | DATA_W | Returned block |
| stat_hit | output | 1 | Pulse: response served by the cache |
| stat_sb | output | 1 | Pulse: response served by the stream buffer |
| stat_miss | output | 1 | Pulse: response served from memory |
| cnt_hit | output | CNT_W | Count of cache hits |
| cnt_sb | output | CNT_W | Count of stream buffer hits |
| cnt_miss | output | CNT_W | Count of full misses |

## Verification
The bench builds the block with 8-bit block addresses, 32-bit blocks and only four cache sets. With so few sets, index conflicts and evictions come up within a handful of fetches, and the address wrap from 255 to 0 is one fetch away. The bench's memory model has a settable latency and an extra gap before each prefetch response. That gap lets it hold a prefetch outstanding while the CPU asks for the same block, or while a full miss to another address kills the entry. It can also throttle request acceptance, so held requests are exercised.

// File: rtl/isb_pkg.sv
package isb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_DEM_REQ,
        ST_PF_REQ,
        ST_DEM_WAIT,
        ST_SB_WAIT
    } isb_state_e;

    localparam int STAT_N    = 3;
    localparam int STAT_HIT  = 0;
    localparam int STAT_SB   = 1;
    localparam int STAT_MISS = 2;

endpackage

// File: rtl/isb_icache_store.sv
module isb_icache_store #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [SETS-1:0]   vld_d, vld_q;
    logic [TAG_W-1:0]  tag_d [SETS];
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_d [SETS];
    logic [DATA_W-1:0] dat_q [SETS];

    logic [IDX_W-1:0] ridx, widx;
    assign ridx = rd_addr[IDX_W-1:0];
    assign widx = wr_addr[IDX_W-1:0];

    // read side: compare the stored tag at the indexed set
    assign rd_hit  = vld_q[ridx] && (tag_q[ridx] == rd_addr[ADDR_W-1:IDX_W]);
    assign rd_data = dat_q[ridx];

    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        dat_d = dat_q;
        if (wr_en) begin
            vld_d[widx] = 1'b1;
            tag_d[widx] = wr_addr[ADDR_W-1:IDX_W];
            dat_d[widx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
        tag_q <= tag_d;
        dat_q <= dat_d;
    end

endmodule

// File: rtl/isb_stream_entry.sv
module isb_stream_entry #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int STALE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              kill,
    input  logic              pf_rsp_valid,
    input  logic [DATA_W-1:0] pf_rsp_data,
    output logic              match,
    output logic              ready,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic               v;
        logic               pend;
        logic [ADDR_W-1:0]  tag;
        logic [DATA_W-1:0]  data;
        logic [STALE_W-1:0] stale;
    } sb_s;

    sb_s sb_d, sb_q;

    assign match = sb_q.v && (sb_q.tag == look_addr);
    assign ready = match && !sb_q.pend;
    assign data  = sb_q.data;

    // order inside one cycle: arriving data, then invalidation, then a new allocation
    always_comb begin
        sb_d = sb_q;
        if (pf_rsp_valid) begin
            if (sb_q.stale != '0) begin
                sb_d.stale = sb_q.stale - 1'b1;
            end else if (sb_q.pend) begin
                sb_d.data = pf_rsp_data;
                sb_d.pend = 1'b0;
            end
        end
        if (kill) begin
            sb_d.v = 1'b0;
            if (sb_d.pend) begin
                sb_d.pend  = 1'b0;
                sb_d.stale = sb_d.stale + 1'b1;
            end
        end
        if (alloc) begin
            sb_d.v    = 1'b1;
            sb_d.pend = 1'b1;
            sb_d.tag  = alloc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_q <= '0;
        end else begin
            sb_q <= sb_d;
        end
    end

endmodule

// File: rtl/isb_stat_counters.sv
module isb_stat_counters #(
    parameter int N     = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     inc,
    output logic [N*CNT_W-1:0] cnt
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [CNT_W-1:0] c_d, c_q;
        always_comb begin
            c_d = c_q;
            if (inc[g]) c_d = c_q + 1'b1;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end
        assign cnt[g*CNT_W +: CNT_W] = c_q;
    end

endmodule

// File: rtl/isb_ctrl.sv
module isb_ctrl
    import isb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_data,
    output logic [STAT_N-1:0] stat,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_pf,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_pf,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic [ADDR_W-1:0] cur_addr,
    input  logic              ch_hit,
    input  logic [DATA_W-1:0] ch_data,
    output logic              cw_en,
    output logic [DATA_W-1:0] cw_data,
    input  logic              sb_match,
    input  logic              sb_ready,
    input  logic [DATA_W-1:0] sb_data,
    output logic              sb_alloc,
    output logic [ADDR_W-1:0] sb_alloc_addr,
    output logic              sb_kill
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        isb_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              dem;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
        logic [STAT_N-1:0] stat;
    } ctl_s;

    ctl_s c_d, c_q;

    logic dem_arrives;
    assign dem_arrives = mem_rsp_valid && !mem_rsp_pf;

    assign cpu_req_ready = (c_q.st == ST_IDLE);
    assign cpu_rsp_valid = c_q.rsp_v;
    assign cpu_rsp_data  = c_q.rsp_d;
    assign stat          = c_q.stat;
    assign cur_addr      = c_q.addr;
    assign mem_req_valid = (c_q.st == ST_DEM_REQ) || (c_q.st == ST_PF_REQ);
    assign mem_req_pf    = (c_q.st == ST_PF_REQ);
    assign mem_req_addr  = (c_q.st == ST_PF_REQ) ? c_q.addr + ONE : c_q.addr;
    assign sb_alloc_addr = c_q.addr + ONE;

    always_comb begin
        c_d      = c_q;
        c_d.rsp_v = 1'b0;
        c_d.stat  = '0;
        cw_en    = 1'b0;
        cw_data  = mem_rsp_data;
        sb_alloc = 1'b0;
        sb_kill  = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    c_d.addr = cpu_req_addr;
                    c_d.st   = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (ch_hit) begin
                    c_d.rsp_v          = 1'b1;
                    c_d.rsp_d          = ch_data;
                    c_d.stat[STAT_HIT] = 1'b1;
                    c_d.st             = ST_IDLE;
                end else if (sb_match) begin
                    if (sb_ready) begin
                        cw_en             = 1'b1;
                        cw_data           = sb_data;
                        c_d.rsp_v         = 1'b1;
                        c_d.rsp_d         = sb_data;
                        c_d.stat[STAT_SB] = 1'b1;
                        c_d.dem           = 1'b0;
                        c_d.st            = ST_PF_REQ;
                    end else begin
                        c_d.st = ST_SB_WAIT;
                    end
                end else begin
                    sb_kill = 1'b1;
                    c_d.dem = 1'b1;
                    c_d.st  = ST_DEM_REQ;
                end
            end
            ST_DEM_REQ: begin
                if (mem_req_ready) c_d.st = ST_PF_REQ;
            end
            ST_PF_REQ: begin
                // the demand block may come back before the prefetch is accepted
                if (c_q.dem && dem_arrives) begin
                    cw_en               = 1'b1;
                    c_d.rsp_v           = 1'b1;
                    c_d.rsp_d           = mem_rsp_data;
                    c_d.stat[STAT_MISS] = 1'b1;
                    c_d.dem             = 1'b0;
                end
                if (mem_req_ready) begin
                    sb_alloc = 1'b1;
                    c_d.st   = c_d.dem ? ST_DEM_WAIT : ST_IDLE;
                end
            end
            ST_DEM_WAIT: begin
                if (dem_arrives) begin
                    cw_en               = 1'b1;
                    c_d.rsp_v           = 1'b1;
                    c_d.rsp_d           = mem_rsp_data;
                    c_d.stat[STAT_MISS] = 1'b1;
                    c_d.dem             = 1'b0;
                    c_d.st              = ST_IDLE;
                end
            end
            ST_SB_WAIT: begin
                if (sb_ready) c_d.st = ST_LOOK;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

endmodule

// File: rtl/isb_prefetch_top.sv
module isb_prefetch_top
    import isb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int SETS    = 16,
    parameter int CNT_W   = 16,
    parameter int STALE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_req_ready,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_pf,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_pf,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              stat_hit,
    output logic              stat_sb,
    output logic              stat_miss,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_sb,
    output logic [CNT_W-1:0]  cnt_miss
);
    logic [ADDR_W-1:0]       cur_addr;
    logic                    ch_hit;
    logic [DATA_W-1:0]       ch_data;
    logic                    cw_en;
    logic [DATA_W-1:0]       cw_data;
    logic                    sb_match, sb_ready, sb_alloc, sb_kill;
    logic [DATA_W-1:0]       sb_data;
    logic [ADDR_W-1:0]       sb_alloc_addr;
    logic [STAT_N-1:0]       stat;
    logic [STAT_N*CNT_W-1:0] cnt_flat;

    isb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_addr(cpu_req_addr),
        .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rsp_data(cpu_rsp_data), .stat(stat),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_pf(mem_req_pf),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_pf(mem_rsp_pf),
        .mem_rsp_data(mem_rsp_data), .cur_addr(cur_addr),
        .ch_hit(ch_hit), .ch_data(ch_data), .cw_en(cw_en), .cw_data(cw_data),
        .sb_match(sb_match), .sb_ready(sb_ready), .sb_data(sb_data),
        .sb_alloc(sb_alloc), .sb_alloc_addr(sb_alloc_addr), .sb_kill(sb_kill)
    );

    isb_icache_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(cur_addr), .rd_hit(ch_hit), .rd_data(ch_data),
        .wr_en(cw_en), .wr_addr(cur_addr), .wr_data(cw_data)
    );

    isb_stream_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STALE_W(STALE_W)) u_sb (
        .clk(clk), .rst_n(rst_n),
        .look_addr(cur_addr), .alloc(sb_alloc), .alloc_addr(sb_alloc_addr),
        .kill(sb_kill), .pf_rsp_valid(mem_rsp_valid && mem_rsp_pf),
        .pf_rsp_data(mem_rsp_data),
        .match(sb_match), .ready(sb_ready), .data(sb_data)
    );

    isb_stat_counters #(.N(STAT_N), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(stat), .cnt(cnt_flat)
    );

    assign stat_hit  = stat[STAT_HIT];
    assign stat_sb   = stat[STAT_SB];
    assign stat_miss = stat[STAT_MISS];
    assign cnt_hit   = cnt_flat[STAT_HIT*CNT_W  +: CNT_W];
    assign cnt_sb    = cnt_flat[STAT_SB*CNT_W   +: CNT_W];
    assign cnt_miss  = cnt_flat[STAT_MISS*CNT_W +: CNT_W];

endmodule

// File: rtl/isb_prefetch_chk.sv
module isb_prefetch_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic [ADDR_W-1:0] cpu_req_addr,
    input logic              cpu_req_ready,
    input logic              cpu_rsp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_pf,
    input logic              stat_hit,
    input logic              stat_sb,
    input logic              stat_miss,
    input logic [CNT_W-1:0]  cnt_hit,
    input logic [CNT_W-1:0]  cnt_sb,
    input logic [CNT_W-1:0]  cnt_miss
);
    logic [CNT_W+1:0]  cnt_sum;
    logic [ADDR_W-1:0] last_addr;

    assign cnt_sum = (CNT_W+2)'(cnt_hit) + (CNT_W+2)'(cnt_sb) + (CNT_W+2)'(cnt_miss);

    always_ff @(posedge clk) begin
        if (!rst_n)                             last_addr <= '0;
        else if (cpu_req_valid && cpu_req_ready) last_addr <= cpu_req_addr;
    end

    assert_one_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rsp_valid == (stat_hit || stat_sb || stat_miss))
        && $onehot0({stat_hit, stat_sb, stat_miss}));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> (cnt_sum == $past(cnt_sum) + 1'b1));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_pf)));

    assert_pf_follows_demand_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && !mem_req_pf) |=>
        (mem_req_valid && mem_req_pf && (mem_req_addr == $past(mem_req_addr) + 1'b1)));

    assert_sb_hit_prefetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_sb |-> (mem_req_valid && mem_req_pf && (mem_req_addr == last_addr + 1'b1)));

endmodule

bind isb_prefetch_top isb_prefetch_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_isb_prefetch_top.sv
module sim_isb_prefetch_top;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NS = 4;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic          cpu_req_ready, cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_data;
    logic          mem_req_valid, mem_req_pf;
    logic          mem_req_ready = 1'b1;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0, mem_rsp_pf = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          stat_hit, stat_sb, stat_miss;
    logic [CW-1:0] cnt_hit, cnt_sb, cnt_miss;

    always #4 clk = ~clk;

    isb_prefetch_top #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .CNT_W(CW)) u0 (.*);

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
        return {a, 8'hA5, ~a, a ^ 8'h3C};
    endfunction

    // behavioural reference state
    bit            m_val [NS];
    logic [AW-1:0] m_blk [NS];
    bit            m_sbv = 1'b0;
    logic [AW-1:0] m_sbt = '0;
    int            n_hit = 0, n_sb = 0, n_miss = 0;
    logic [8:0]    exp_mq [$];
    bit            exp_pending = 1'b0;
    logic [DW-1:0] exp_data;
    logic [2:0]    exp_cls;
    string         exp_rq;

    // memory model
    typedef struct packed { logic [AW-1:0] a; logic pf; logic [31:0] due; } pend_t;
    pend_t pq [$];
    int    mem_lat = 3, pf_gap = 1, last_due = 0;
    bit    ready_mode = 1'b0;
    bit    prev_wait = 1'b0;
    logic [AW-1:0] prev_addr;
    logic          prev_pf;

    always @(negedge clk) begin
        cyc++;
        if (pq.size() > 0 && int'(pq[0].due) <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_pf    = pq[0].pf;
            mem_rsp_data  = blk(pq[0].a);
            void'(pq.pop_front());
        end else begin
            mem_rsp_valid = 1'b0;
        end
        mem_req_ready = ready_mode ? ((cyc % 3) != 1) : 1'b1;
        #1;
        if (rst_n) begin
            if (prev_wait)
                check(mem_req_valid && mem_req_addr == prev_addr && mem_req_pf == prev_pf,
                      "R10", "held request", {mem_req_valid, mem_req_pf, mem_req_addr},
                      {1'b1, prev_pf, prev_addr});
            prev_wait = mem_req_valid && !mem_req_ready;
            prev_addr = mem_req_addr;
            prev_pf   = mem_req_pf;
            if (mem_req_valid && mem_req_ready) begin
                if (exp_mq.size() == 0) begin
                    check(1'b0, "R7", "unexpected memory request", {mem_req_pf, mem_req_addr}, 0);
                end else begin
                    check({mem_req_pf, mem_req_addr} == exp_mq[0], "R3", "memory request order",
                          {mem_req_pf, mem_req_addr}, exp_mq[0]);
                    void'(exp_mq.pop_front());
                end
                begin
                    int d;
                    d = mem_req_pf ? last_due + pf_gap : last_due + 1;
                    if (d < cyc + 1 + mem_lat) d = cyc + 1 + mem_lat;
                    last_due = d;
                    pq.push_back('{a: mem_req_addr, pf: mem_req_pf, due: 32'(d)});
                end
            end
            if (cpu_rsp_valid) begin
                if (!exp_pending) begin
                    check(1'b0, "R9", "unexpected response", cpu_rsp_data, 0);
                end else begin
                    check(cpu_rsp_data == exp_data, exp_rq, "response data", cpu_rsp_data, exp_data);
                    check({stat_miss, stat_sb, stat_hit} == exp_cls, exp_rq, "response class",
                          {stat_miss, stat_sb, stat_hit}, exp_cls);
                    exp_pending = 1'b0;
                end
            end else if ((stat_hit || stat_sb || stat_miss)) begin
                check(1'b0, "R9", "status without response", {stat_miss, stat_sb, stat_hit}, 0);
            end
        end
    end

    task automatic fetch(input logic [AW-1:0] a, input string rq);
        int idx;
        logic [AW-1:0] nx;
        idx = int'(a) % NS;
        nx  = a + 8'd1;
        if (m_val[idx] && m_blk[idx] == a) begin
            exp_cls = 3'b001; n_hit++;
        end else if (m_sbv && m_sbt == a) begin
            exp_cls = 3'b010; n_sb++;
            exp_mq.push_back({1'b1, nx});
            m_val[idx] = 1'b1; m_blk[idx] = a; m_sbt = nx;
        end else begin
            exp_cls = 3'b100; n_miss++;
            exp_mq.push_back({1'b0, a});
            exp_mq.push_back({1'b1, nx});
            m_val[idx] = 1'b1; m_blk[idx] = a; m_sbv = 1'b1; m_sbt = nx;
        end
        exp_data = blk(a);
        exp_rq = rq;
        exp_pending = 1'b1;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_addr  = a;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        for (int t = 0; t < 400 && exp_pending; t++) @(negedge clk);
        if (exp_pending) begin
            check(1'b0, rq, "response timeout", 0, exp_data);
            exp_pending = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < NS; i++) m_val[i] = 1'b0;
        repeat (5) @(negedge clk);
        #2;
        check(cpu_req_ready == 1'b1 && cpu_rsp_valid == 1'b0 && mem_req_valid == 1'b0,
              "R1", "idle after reset", {cpu_req_ready, cpu_rsp_valid, mem_req_valid}, 3'b100);
        check(cnt_hit == 0 && cnt_sb == 0 && cnt_miss == 0, "R1", "counters after reset",
              {cnt_hit, cnt_sb, cnt_miss}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // basic classes, promotion and conflict eviction
        fetch(8'd8,  "R4");
        fetch(8'd8,  "R2");
        fetch(8'd9,  "R5");
        fetch(8'd9,  "R6");
        fetch(8'd10, "R6");
        fetch(8'd12, "R3");
        fetch(8'd8,  "R2");

        // throttled acceptance over a sequential run
        ready_mode = 1'b1; mem_lat = 5;
        fetch(8'd20, "R3");
        fetch(8'd21, "R6");
        fetch(8'd22, "R6");
        fetch(8'd23, "R10");
        fetch(8'd24, "R6");
        ready_mode = 1'b0;

        // buffer hit while its prefetch is still in flight
        mem_lat = 4; pf_gap = 14;
        fetch(8'd60, "R4");
        fetch(8'd61, "R7");
        fetch(8'd62, "R7");

        // kill with a late prefetch pending, then use the new entry
        pf_gap = 22;
        fetch(8'd40,  "R4");
        fetch(8'd100, "R8");
        fetch(8'd101, "R8");
        pf_gap = 1;

        // address wrap
        fetch(8'd255, "R3");
        fetch(8'd0,   "R3");

        repeat (80) @(negedge clk);
        #2;
        check(exp_mq.size() == 0, "R3", "requests outstanding", exp_mq.size(), 0);
        check(cnt_hit == CW'(n_hit), "R9", "hit counter", cnt_hit, n_hit);
        check(cnt_sb == CW'(n_sb), "R9", "buffer hit counter", cnt_sb, n_sb);
        check(cnt_miss == CW'(n_miss), "R9", "miss counter", cnt_miss, n_miss);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule